// File: doc/BRIEF.md
# MDIO Management Master with Packed Command Word

This block runs Clause 22 management frames toward external PHY devices. Software uses one 32-bit control word. A single write to that word carries the operation, the PHY address, the PHY register address and, for a write, the data. When the word is a valid command, the block sends a complete serial frame on the management clock and data pins. While the frame runs, bit 31 of the word reads back as 1.

The management clock comes from the system clock through a divider whose half period is a parameter. The data pin changes while the clock is low and is sampled on the clock's rising edge. For a read, the block releases the data pin for the turnaround and data fields. It shifts in the 16 returned bits and places them in bits 15:0 of the control word when the frame ends. A command to a PHY address at or above the supported count starts no frame. A read of such an address returns 0xFFFF.

Top module: `mdio_cmd_engine`

## Requirements
- R1: Out of reset the control word reads 0, the management clock is low and the data output enable is low.
- R2: A write command sends 64 bits, most significant first: 32 ones, then 01, then opcode 01, then the 5-bit PHY address, then the 5-bit register address, then 10, then the 16 data bits. The output enable is high for all 64 bits.
- R3: A read command sends the same header with opcode 10. The output enable is low for bit positions 46 to 63 (the turnaround and the data field). The 16 bits sampled at the rising clock edges of positions 48 to 63 appear in control bits 15:0, first bit highest, once the frame ends.
- R4: After a command is accepted, bit 31 reads 1 from the next cycle until the frame ends, and then reads 0. A new command written in the first cycle after bit 31 reads 0 is accepted.
- R5: The management clock period is 2*DIV_HALF system clocks. The clock is low while idle. The data output changes only while the clock is low.
- R6: A write with bit 30 (enable) or bit 31 (busy request) clear starts no frame, and bit 31 reads 0 afterward.
- R7: A command whose PHY address (bits 25:21) is NUM_PHYS or higher starts no frame and leaves bit 31 at 0. If it is a read, control bits 15:0 read 0xFFFF.
- R8: While bit 31 reads 1, any write to the control word is ignored. The frame in flight, its result and the stored fields do not change.
- R9: Field positions: bit 27 is 1 for read and 0 for write, bits 20:16 hold the register address, bits 25:21 hold the PHY address, and bits 15:0 hold the data. These fields read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Write strobe for the control word |
| csr_wdata | input | 32 | Control word write value |
| csr_rdata | output | 32 | Control word read value, busy in bit 31 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
A software write to the control word can land in the same cycle that the frame completes and busy is being cleared. The bench provokes this by writing a different command on every cycle of a read frame, up to and including the cycle where the frame ends. It then checks three things: the PHY's read data and the original address fields survive, exactly 64 clock rises occurred, and a command written in the very next cycle starts a fresh frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned TA_IDX     = 46;
  localparam int unsigned DATA_IDX   = 48;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned REG_LSB    = 16;
  localparam int unsigned PHY_LSB    = 21;
  localparam int unsigned OP_BIT     = 27;
  localparam int unsigned EN_BIT     = 30;
  localparam int unsigned BUSY_BIT   = 31;

  typedef struct packed {
    logic              is_read;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_ctrl_reg.sv
module mdio_ctrl_reg
  import mdio_pkg::*;
#(
  parameter int NUM_PHYS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_data,
  output logic [31:0]       csr,
  output logic              start,
  output mdio_cmd_t         cmd
);
  logic [30:0]       word_q, word_d;
  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] phy;
  logic              phy_ok, issue;

  always_comb begin
    phy    = wr_data[PHY_LSB +: ADDR_W];
    phy_ok = int'(phy) < NUM_PHYS;
    issue  = wr_en && !busy_q && wr_data[BUSY_BIT] && wr_data[EN_BIT];
    start  = issue && phy_ok;
    cmd.is_read = wr_data[OP_BIT];
    cmd.phy     = phy;
    cmd.regad   = wr_data[REG_LSB +: ADDR_W];
    cmd.wdata   = wr_data[DATA_W-1:0];
  end

  always_comb begin
    word_d = word_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
        if (word_q[OP_BIT]) word_d[DATA_W-1:0] = rd_data;
      end
    end else if (wr_en) begin
      word_d = wr_data[30:0];
      busy_d = start;
      if (issue && !phy_ok && wr_data[OP_BIT]) word_d[DATA_W-1:0] = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      busy_q <= 1'b0;
    end else begin
      word_q <= word_d;
      busy_q <= busy_d;
    end
  end

  assign csr = {busy_q, word_q};

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> busy_q);
  // R8
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done && wr_en) |=> $stable(word_q));
  // R7
  bad_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy_q && (int'(wr_data[PHY_LSB +: ADDR_W]) >= NUM_PHYS)) |=> !busy_q);
endmodule

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int CNT_W = $clog2(DIV_HALF + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = run && (cnt_q == LAST);
    if (clear || !run || cnt_q == LAST) cnt_d = '0;
    else                                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdio_serializer.sv
module mdio_serializer
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic              tick,
  input  logic              mdio_i,
  output logic              active,
  output logic              done,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [IDX_W-1:0] I_TA   = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] I_DATA = IDX_W'(DATA_IDX);
  localparam logic [IDX_W-1:0] I_LAST = IDX_W'(FRAME_BITS - 1);

  logic                  active_q, active_d, mdc_q, mdc_d, rd_q, rd_d;
  logic                  o_q, o_d, oe_q, oe_d, done_q, done_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [DATA_W-1:0]     cap_q, cap_d;

  always_comb begin
    active_d = active_q; mdc_d = mdc_q; rd_d = rd_q; o_d = o_q; oe_d = oe_q;
    sh_d = sh_q; idx_d = idx_q; cap_d = cap_q; done_d = 1'b0;
    if (start) begin
      sh_d     = {32'hFFFF_FFFF, 2'b01, (cmd.is_read ? 2'b10 : 2'b01),
                  cmd.phy, cmd.regad, 2'b10, cmd.wdata};
      active_d = 1'b1;
      idx_d    = '0;
      mdc_d    = 1'b0;
      o_d      = 1'b1;
      oe_d     = 1'b1;
      rd_d     = cmd.is_read;
      cap_d    = '0;
    end else if (active_q && tick) begin
      if (!mdc_q) begin
        mdc_d = 1'b1;
        if (rd_q && idx_q >= I_DATA) cap_d = {cap_q[DATA_W-2:0], mdio_i};
      end else begin
        mdc_d = 1'b0;
        if (idx_q == I_LAST) begin
          active_d = 1'b0;
          done_d   = 1'b1;
          oe_d     = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
          o_d   = sh_q[FRAME_BITS-2];
          oe_d  = !(rd_q && idx_d >= I_TA);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0; mdc_q <= 1'b0; rd_q <= 1'b0; o_q <= 1'b0;
      oe_q <= 1'b0; done_q <= 1'b0; sh_q <= '0; idx_q <= '0; cap_q <= '0;
    end else begin
      active_q <= active_d; mdc_q <= mdc_d; rd_q <= rd_d; o_q <= o_d;
      oe_q <= oe_d; done_q <= done_d; sh_q <= sh_d; idx_q <= idx_d; cap_q <= cap_d;
    end
  end

  assign active  = active_q;
  assign done    = done_q;
  assign mdc     = mdc_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign rd_data = cap_q;

  // R5
  mdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(o_q) |-> !mdc_q);
  // R5
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !mdc_q);
  // R3
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && mdc_q && idx_q >= I_TA) |-> !oe_q);
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int NUM_PHYS = 5,
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              start, done, tick, active;
  logic [DATA_W-1:0] rd_data;
  mdio_cmd_t         cmd;

  mdio_ctrl_reg #(.NUM_PHYS(NUM_PHYS)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_wr), .wr_data(csr_wdata),
    .done(done), .rd_data(rd_data), .csr(csr_rdata), .start(start), .cmd(cmd)
  );

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) i_div (
    .clk(clk), .rst_n(rst_n), .run(active), .clear(start), .tick(tick)
  );

  mdio_serializer i_ser (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .tick(tick),
    .mdio_i(mdio_i), .active(active), .done(done), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
  );

  // R4
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && csr_rdata[BUSY_BIT]));
  // R6
  no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !csr_rdata[BUSY_BIT] && !(csr_wdata[BUSY_BIT] && csr_wdata[EN_BIT]))
    |=> !active);
endmodule

// File: tb/test_mdio_cmd_engine.sv
module test_mdio_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int NPHY = 5;

  logic        clk, rst_n, csr_wr, mdio_i;
  logic [31:0] csr_wdata, csr_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int          checks = 0;
  int          fails = 0;
  int          rise_cnt = 0;
  logic [63:0] obs_bits, obs_oe;
  logic [15:0] phy_rd_val = 16'h0000;
  longint      t_r1, t_r2;

  mdio_cmd_engine #(.NUM_PHYS(NPHY), .DIV_HALF(DIV)) i_mdio_cmd_engine (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // PHY side: record each bit at the rising clock edge
  initial begin
    forever begin
      @(posedge mdc);
      obs_bits = {obs_bits[62:0], mdio_o};
      obs_oe   = {obs_oe[62:0], mdio_oe};
      if (rise_cnt == 0) t_r1 = longint'($time);
      if (rise_cnt == 1) t_r2 = longint'($time);
      rise_cnt++;
    end
  end

  // PHY side: drive turnaround zero and read data after the falling edge
  initial begin
    mdio_i = 1'b1;
    forever begin
      @(negedge mdc);
      if (rise_cnt >= 48 && rise_cnt <= 63) mdio_i = phy_rd_val[63 - rise_cnt];
      else if (rise_cnt == 47)              mdio_i = 1'b0;
      else                                  mdio_i = 1'b1;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic rd, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] d,
                                     input logic en, input logic bsy);
    logic [31:0] w;
    w = '0;
    w[31] = bsy; w[30] = en; w[27] = rd;
    w[25:21] = phy; w[20:16] = rg; w[15:0] = d;
    return w;
  endfunction

  task automatic issue(input logic [31:0] w);
    rise_cnt = 0;
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = w;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (csr_rdata[31] && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 csr", {32'h0, csr_rdata}, 64'h0);
    check("R1 mdc", {63'h0, mdc}, 64'h0);
    check("R1 oe", {63'h0, mdio_oe}, 64'h0);
  endtask

  task automatic t_write();
    issue(mk(1'b0, 5'd2, 5'd5, 16'hA5C3, 1'b1, 1'b1));
    check("R4 busy set", {63'h0, csr_rdata[31]}, 64'h1);
    wait_idle();
    check("R2 frame bits", obs_bits,
          {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd2, 5'd5, 2'b10, 16'hA5C3});
    check("R2 oe", obs_oe, {64{1'b1}});
    check("R2 bit count", 64'(rise_cnt), 64'd64);
    check("R5 mdc period", 64'(t_r2 - t_r1), 64'(2 * DIV * CLK_PERIOD));
    check("R4 busy clear", {63'h0, csr_rdata[31]}, 64'h0);
    check("R5 idle mdc", {63'h0, mdc}, 64'h0);
    check("R9 fields", {59'h0, csr_rdata[27], csr_rdata[25:21]}, {59'h0, 1'b0, 5'd2});
  endtask

  task automatic t_read();
    phy_rd_val = 16'h1234;
    issue(mk(1'b1, 5'd4, 5'd31, 16'h0000, 1'b1, 1'b1));
    wait_idle();
    check("R3 header", {18'h0, obs_bits[63:18]},
          {18'h0, 32'hFFFF_FFFF, 2'b01, 2'b10, 5'd4, 5'd31});
    check("R3 oe release", obs_oe, {{46{1'b1}}, {18{1'b0}}});
    check("R3 read data", {48'h0, csr_rdata[15:0]}, {48'h0, 16'h1234});
    check("R9 read fields", {53'h0, csr_rdata[27], csr_rdata[25:16]},
          {53'h0, 1'b1, 5'd4, 5'd31});
  endtask

  task automatic t_no_cmd();
    issue(mk(1'b0, 5'd1, 5'd1, 16'h5555, 1'b0, 1'b1));
    repeat (40) @(negedge clk);
    check("R6 no enable busy", {63'h0, csr_rdata[31]}, 64'h0);
    check("R6 no enable frame", 64'(rise_cnt), 64'd0);
    issue(mk(1'b0, 5'd1, 5'd1, 16'h5555, 1'b1, 1'b0));
    repeat (40) @(negedge clk);
    check("R6 no request busy", {63'h0, csr_rdata[31]}, 64'h0);
    check("R6 no request frame", 64'(rise_cnt), 64'd0);
  endtask

  task automatic t_bad_phy();
    issue(mk(1'b1, 5'd5, 5'd2, 16'h0000, 1'b1, 1'b1));
    check("R7 bad read busy", {63'h0, csr_rdata[31]}, 64'h0);
    repeat (40) @(negedge clk);
    check("R7 bad read frame", 64'(rise_cnt), 64'd0);
    check("R7 bad read data", {48'h0, csr_rdata[15:0]}, {48'h0, 16'hFFFF});
    issue(mk(1'b0, 5'd31, 5'd2, 16'h1357, 1'b1, 1'b1));
    repeat (40) @(negedge clk);
    check("R7 bad write busy", {63'h0, csr_rdata[31]}, 64'h0);
    check("R7 bad write frame", 64'(rise_cnt), 64'd0);
  endtask

  task automatic t_busy_ignore();
    int n = 0;
    phy_rd_val = 16'hBEEF;
    issue(mk(1'b1, 5'd1, 5'd3, 16'h0000, 1'b1, 1'b1));
    while (csr_rdata[31] && n < 5000) begin
      csr_wr = 1'b1;
      csr_wdata = mk(1'b0, 5'd0, 5'd9, 16'h0F0F, 1'b1, 1'b1);
      @(negedge clk);
      n++;
    end
    csr_wr = 1'b0;
    check("R8 read data kept", {48'h0, csr_rdata[15:0]}, {48'h0, 16'hBEEF});
    check("R8 fields kept", {54'h0, csr_rdata[25:16]}, {54'h0, 5'd1, 5'd3});
    check("R8 single frame", 64'(rise_cnt), 64'd64);
    rise_cnt = 0;
    csr_wr = 1'b1;
    csr_wdata = mk(1'b0, 5'd3, 5'd0, 16'h1111, 1'b1, 1'b1);
    @(negedge clk);
    csr_wr = 1'b0;
    check("R4 back-to-back accept", {63'h0, csr_rdata[31]}, 64'h1);
    wait_idle();
    check("R4 back-to-back frame", obs_bits,
          {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'd0, 2'b10, 16'h1111});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    csr_wr = 1'b0;
    csr_wdata = '0;
    obs_bits = '0;
    obs_oe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_no_cmd();
    t_bad_phy();
    t_busy_ignore();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule